// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Level-One Read Cache

This block is a 16 KB, 4-way set-associative level-one data cache that is read only. It holds 128 sets of four 32-byte lines. A load presents the page-offset part of its virtual address. Bits 11..2 of that address arrive as a word address inside the page. The cache captures the set index and the word position at once, so the set can be looked up before address translation has finished.

The 20-bit physical page number comes from the translation path, possibly some cycles later, with its own valid flag. The four stored tags of the selected set are compared against it once that flag is seen.

A hit returns the addressed 32-bit word. A miss raises a request for the line to the next level. The line then arrives as eight words in order. It is installed in a way chosen by an invalid-first, tree pseudo-LRU policy, and the requested word is returned with the hit flag low.

Top module: `vipt_l1_cache`

## Requirements
- R1: A miss requests the line at physical address {ppn[19:0], index[6:0], 5'b00000}, where index is rd_vword[9:3] and the word within the line is rd_vword[2:0].
- R2: After reset, req_ready is 1, resp_valid and miss_req are 0, and no line is valid, so the first read of any address misses.
- R3: When the translated page number matches the tag of a valid way in the indexed set, the cache returns resp_valid=1 and resp_hit=1 with the word at position rd_vword[2:0] of that line. This happens one cycle after the clock edge that sampled ppn_valid high, and resp_valid lasts exactly one cycle.
- R4: On a miss, miss_req rises and stays high until the clock edge that samples miss_gnt high, and miss_addr holds the line address during that time.
- R5: After the grant, the eight words of the line are accepted on fill_valid beats, with beat k written to word k. Gaps between beats are allowed. The response (resp_hit=0, the requested word) comes one cycle after the last beat and never earlier, and only then does the line become valid for later hits.
- R6: While ppn_valid is low after a strobe, the cache produces no response and no miss request, and it ignores the value on ppn. The lookup continues when ppn_valid rises.
- R7: A miss fills the lowest-numbered invalid way of the set before any valid way is replaced.
- R8: With all four ways valid, the victim comes from three per-set bits b0..b2 (all 0 after reset). If b0=0, the victim is way b1 (0 or 1). If b0=1, the victim is way 2+b2. An access to way w (hit or fill) sets b0 = 1 if w<2 and 0 otherwise. It also sets b1 = (w==0) when w<2, or b2 = (w==2) when w≥2.
- R9: req_ready is 1 only when the cache is idle. A strobe on rd_req while req_ready is 0 is ignored and produces no response or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_ready | output | 1 | Cache idle, a read strobe will be accepted |
| rd_req | input | 1 | Read strobe |
| rd_vword | input | 10 | Virtual address bits 11..2 (set index and word in line) |
| ppn | input | 20 | Physical page number from translation |
| ppn_valid | input | 1 | ppn holds the translation for the pending read |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response was a hit (1) or served by refill (0) |
| resp_data | output | 32 | Returned word |
| miss_req | output | 1 | Line request to the next level |
| miss_addr | output | 32 | Line-aligned physical address of the request |
| miss_gnt | input | 1 | Next level accepts the request |
| fill_valid | input | 1 | One refill word is on fill_data |
| fill_data | input | 32 | Refill word, in line order |

## Verification
A corrupted valid bit or tag shows up at the ports as a wrong hit flag on the next read of that line. A corrupted tag can also raise miss_req with an address the scoreboard does not expect. Either way, it appears within two cycles of the translation arriving.

A wrong pseudo-LRU bit stays hidden until a set is full. It then evicts a different line, and the error appears as an unexpected miss, or an unexpected hit, on a later revisit of the set. The directed sequence therefore fills sets, reorders accesses and revisits every line.

Misordered refill beats appear as wrong words on later hits at other word positions. A missing wait for translation appears as a response or request while ppn_valid is low.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_MREQ,
        ST_FILL,
        ST_RESP
    } cst_e;

    // tree pseudo-LRU: bit0 chooses the half, bit1/bit2 the way inside it
    function automatic logic [WAY_W-1:0] plru_pick(input logic [2:0] b);
        if (!b[0]) return {1'b0, b[1]};
        return {1'b1, b[2]};
    endfunction

    // point the tree away from the way just used
    function automatic logic [2:0] plru_upd(input logic [2:0] b, input logic [WAY_W-1:0] w);
        logic [2:0] n;
        n    = b;
        n[0] = ~w[1];
        if (!w[1]) n[1] = ~w[0];
        else       n[2] = ~w[0];
        return n;
    endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
    import vipt_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int TAG_W = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(SETS)-1:0]      rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0]              rd_vld,
    input  logic                         we,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [$clog2(SETS)-1:0]      wr_set,
    input  logic [TAG_W-1:0]             wr_tag
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld_q;

        always_ff @(posedge clk) begin
            if (we && wr_way == WAY_W'(w)) tag_mem[wr_set] <= wr_tag;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          vld_q <= '0;
            else if (we && wr_way == WAY_W'(w))  vld_q[wr_set] <= 1'b1;
        end

        assign rd_tag[w] = tag_mem[rd_set];
        assign rd_vld[w] = vld_q[rd_set];
    end

endmodule

// File: rtl/vipt_line_store.sv
module vipt_line_store
    import vipt_pkg::*;
#(
    parameter int SETS   = 128,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic [$clog2(SETS)-1:0]       rd_set,
    input  logic [$clog2(WORDS)-1:0]      rd_word,
    output logic [WAYS-1:0][DATA_W-1:0]   rd_data,
    input  logic                          we,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [$clog2(SETS)-1:0]       wr_set,
    input  logic [$clog2(WORDS)-1:0]      wr_word,
    input  logic [DATA_W-1:0]             wr_data
);

    localparam int DEPTH = SETS * WORDS;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wr_way == WAY_W'(w)) mem[{wr_set, wr_word}] <= wr_data;
        end

        assign rd_data[w] = mem[{rd_set, rd_word}];
    end

endmodule

// File: rtl/vipt_plru_store.sv
module vipt_plru_store #(
    parameter int SETS = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  set,
    output logic [2:0]               rd_bits,
    input  logic                     we,
    input  logic [2:0]               wr_bits
);

    logic [2:0] bits_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) bits_q[s] <= 3'b000;
        end else if (we) begin
            bits_q[set] <= wr_bits;
        end
    end

    assign rd_bits = bits_q[set];

endmodule

// File: rtl/vipt_l1_cache.sv
module vipt_l1_cache
    import vipt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int PAGE_BITS  = 12,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 128
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    output logic                                  req_ready,
    input  logic                                  rd_req,
    input  logic [PAGE_BITS-$clog2(DATA_W/8)-1:0] rd_vword,
    input  logic [ADDR_W-PAGE_BITS-1:0]           ppn,
    input  logic                                  ppn_valid,
    output logic                                  resp_valid,
    output logic                                  resp_hit,
    output logic [DATA_W-1:0]                     resp_data,
    output logic                                  miss_req,
    output logic [ADDR_W-1:0]                     miss_addr,
    input  logic                                  miss_gnt,
    input  logic                                  fill_valid,
    input  logic [DATA_W-1:0]                     fill_data
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WOFF_W     = $clog2(WORDS);
    localparam int IDX_W      = $clog2(SETS);
    localparam int TAG_W      = ADDR_W - PAGE_BITS;
    localparam int LOW_W      = ADDR_W - TAG_W - IDX_W;

    typedef struct packed {
        cst_e              st;
        logic [IDX_W-1:0]  idx;
        logic [WOFF_W-1:0] wrd;
        logic [TAG_W-1:0]  tag;
        logic [WAY_W-1:0]  vic;
        logic [WOFF_W-1:0] cnt;
        logic              rv;
        logic              rh;
        logic [DATA_W-1:0] rd;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, default: '0};

    ctl_t s_d, s_q;

    logic [WAYS-1:0][TAG_W-1:0]  tag_rd;
    logic [WAYS-1:0]             vld_rd;
    logic [WAYS-1:0][DATA_W-1:0] word_rd;
    logic [2:0]                  plru_rd, plru_wr;
    logic                        tag_we, data_we, plru_we;
    logic [WAYS-1:0]             hit_vec;
    logic [WAY_W-1:0]            hit_way, inv_way;
    logic                        inv_found;

    vipt_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_set (s_q.idx),
        .rd_tag (tag_rd),
        .rd_vld (vld_rd),
        .we     (tag_we),
        .wr_way (s_q.vic),
        .wr_set (s_q.idx),
        .wr_tag (s_q.tag)
    );

    vipt_line_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_lines (
        .clk     (clk),
        .rd_set  (s_q.idx),
        .rd_word (s_q.wrd),
        .rd_data (word_rd),
        .we      (data_we),
        .wr_way  (s_q.vic),
        .wr_set  (s_q.idx),
        .wr_word (s_q.cnt),
        .wr_data (fill_data)
    );

    vipt_plru_store #(.SETS(SETS)) u_plru (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (s_q.idx),
        .rd_bits (plru_rd),
        .we      (plru_we),
        .wr_bits (plru_wr)
    );

    // tag compare against the translated page, plus way encoders
    always_comb begin
        hit_way   = '0;
        inv_way   = '0;
        inv_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = vld_rd[w] && (tag_rd[w] == ppn);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_rd[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
    end

    always_comb begin
        s_d     = s_q;
        s_d.rv  = 1'b0;
        s_d.rh  = 1'b0;
        tag_we  = 1'b0;
        data_we = 1'b0;
        plru_we = 1'b0;
        plru_wr = plru_rd;
        case (s_q.st)
            ST_IDLE: begin
                if (rd_req) begin
                    s_d.wrd = rd_vword[WOFF_W-1:0];
                    s_d.idx = rd_vword[WOFF_W +: IDX_W];
                    s_d.st  = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (ppn_valid) begin
                    if (|hit_vec) begin
                        s_d.rv  = 1'b1;
                        s_d.rh  = 1'b1;
                        s_d.rd  = word_rd[hit_way];
                        plru_we = 1'b1;
                        plru_wr = plru_upd(plru_rd, hit_way);
                        s_d.st  = ST_IDLE;
                    end else begin
                        s_d.tag = ppn;
                        s_d.vic = inv_found ? inv_way : plru_pick(plru_rd);
                        s_d.st  = ST_MREQ;
                    end
                end
            end
            ST_MREQ: begin
                if (miss_gnt) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_FILL;
                end
            end
            ST_FILL: begin
                if (fill_valid) begin
                    data_we = 1'b1;
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == WOFF_W'(WORDS - 1)) begin
                        tag_we  = 1'b1;
                        plru_we = 1'b1;
                        plru_wr = plru_upd(plru_rd, s_q.vic);
                        s_d.st  = ST_RESP;
                    end
                end
            end
            ST_RESP: begin
                s_d.rv = 1'b1;
                s_d.rd = word_rd[s_q.vic];
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CTL_RST;
        else        s_q <= s_d;
    end

    assign req_ready  = (s_q.st == ST_IDLE);
    assign resp_valid = s_q.rv;
    assign resp_hit   = s_q.rh;
    assign resp_data  = s_q.rd;
    assign miss_req   = (s_q.st == ST_MREQ);
    assign miss_addr  = {s_q.tag, s_q.idx, LOW_W'(0)};

endmodule

// File: rtl/vipt_l1_cache_chk.sv
module vipt_l1_cache_chk
    import vipt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            resp_valid,
    input logic            resp_hit,
    input logic            miss_req,
    input logic            miss_gnt,
    input logic            ppn_valid,
    input logic            fill_valid,
    input logic [WAYS-1:0] hit_vec
);

    // R4
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req && !miss_gnt |=> miss_req);

    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !miss_req);

    // R6
    hit_needs_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_hit |-> $past(ppn_valid));

    // R3
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R3
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R5
    fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> $past(fill_valid, 2));

endmodule

bind vipt_l1_cache vipt_l1_cache_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .miss_req   (miss_req),
    .miss_gnt   (miss_gnt),
    .ppn_valid  (ppn_valid),
    .fill_valid (fill_valid),
    .hit_vec    (hit_vec)
);

// File: tb/vipt_l1_cache_test.sv
module vipt_l1_cache_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_ready;
    logic        rd_req = 1'b0;
    logic [9:0]  rd_vword = '0;
    logic [19:0] ppn = '0;
    logic        ppn_valid = 1'b0;
    logic        resp_valid, resp_hit;
    logic [31:0] resp_data;
    logic        miss_req;
    logic [31:0] miss_addr;
    logic        miss_gnt = 1'b0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    always #2.5 clk = ~clk;

    vipt_l1_cache uut (
        .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_req(rd_req),
        .rd_vword(rd_vword), .ppn(ppn), .ppn_valid(ppn_valid),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .miss_req(miss_req), .miss_addr(miss_addr), .miss_gnt(miss_gnt),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    int nchk = 0;
    int nerr = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] pa);
        return {pa[31:2], 2'b00} ^ 32'hC3A5_5A3C;
    endfunction

    // reference state, built from R7/R8
    logic [19:0] m_tag  [128][4];
    bit          m_vld  [128][4];
    logic [2:0]  m_plru [128];

    typedef struct {
        bit          hit;
        logic [31:0] data;
    } exp_t;
    exp_t        rq[$];
    logic [31:0] mq[$];

    int gap_mode = 0;
    int gnt_dly  = 0;

    function automatic int model_access(input logic [19:0] t, input logic [6:0] idx, output bit hit);
        int way;
        logic [2:0] b;
        hit = 1'b0;
        way = -1;
        for (int w = 0; w < 4; w++)
            if (m_vld[idx][w] && m_tag[idx][w] == t) begin hit = 1'b1; way = w; end
        if (!hit) begin
            for (int w = 3; w >= 0; w--) if (!m_vld[idx][w]) way = w;
            if (way < 0) begin
                b = m_plru[idx];
                if (b[0] == 1'b0) way = b[1] ? 1 : 0;
                else              way = b[2] ? 3 : 2;
            end
            m_vld[idx][way] = 1'b1;
            m_tag[idx][way] = t;
        end
        b = m_plru[idx];
        case (way)
            0: begin b[0] = 1'b1; b[1] = 1'b1; end
            1: begin b[0] = 1'b1; b[1] = 1'b0; end
            2: begin b[0] = 1'b0; b[2] = 1'b1; end
            default: begin b[0] = 1'b0; b[2] = 1'b0; end
        endcase
        m_plru[idx] = b;
        return way;
    endfunction

    // driver: predicts, pushes expectations, drives the read
    task automatic do_read(input logic [19:0] t, input logic [6:0] idx, input logic [2:0] wrd,
                           input int dly, input bit poke);
        bit   hit;
        int   way;
        exp_t e;
        way    = model_access(t, idx, hit);
        e.hit  = hit;
        e.data = word_of({t, idx, wrd, 2'b00});
        rq.push_back(e);
        if (!hit) mq.push_back({t, idx, 5'b00000});
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_req   = 1'b1;
        rd_vword = {idx, wrd};
        @(negedge clk);
        rd_req = 1'b0;
        for (int k = 0; k < dly; k++) begin
            ppn       = t ^ 20'hFFFFF;
            ppn_valid = 1'b0;
            @(negedge clk);
            // R6: nothing happens while translation is pending
            check(!resp_valid && !miss_req, "R6 no activity before ppn_valid",
                  {30'd0, resp_valid, miss_req}, 32'd0);
        end
        ppn       = t;
        ppn_valid = 1'b1;
        if (poke) begin
            repeat (3) @(negedge clk);
            rd_req   = 1'b1;
            rd_vword = {idx ^ 7'h11, 3'd0};
            check(!req_ready, "R9 busy during refill", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            rd_req = 1'b0;
        end else begin
            @(negedge clk);
            if (hit)
                check(resp_valid === 1'b1, "R3 hit latency", {31'd0, resp_valid}, 32'd1);
        end
        while (!resp_valid) @(negedge clk);
        ppn_valid = 1'b0;
    endtask

    // monitor: pops scoreboard on every response
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (rq.size() == 0) begin
                check(1'b0, "R9 unexpected response", resp_data, 32'd0);
            end else begin
                exp_t e;
                e = rq.pop_front();
                check(resp_hit == e.hit, e.hit ? "R3 hit flag" : "R2/R7/R8 miss flag",
                      {31'd0, resp_hit}, {31'd0, e.hit});
                check(resp_data == e.data, e.hit ? "R3 hit data" : "R5 refill data",
                      resp_data, e.data);
            end
        end
    end

    // next level: grants and streams lines
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && miss_req) begin
                logic [31:0] ea;
                ea = (mq.size() != 0) ? mq.pop_front() : 32'hDEAD_BEEF;
                check(miss_addr == ea, "R1 miss address", miss_addr, ea);
                for (int d = 0; d < gnt_dly; d++) begin
                    @(negedge clk);
                    check(miss_req === 1'b1, "R4 request held until grant", {31'd0, miss_req}, 32'd1);
                end
                miss_gnt = 1'b1;
                @(negedge clk);
                miss_gnt = 1'b0;
                for (int k = 0; k < 8; k++) begin
                    if (gap_mode != 0 && (k % 2) == 1) begin
                        fill_valid = 1'b0;
                        @(negedge clk);
                    end
                    if (k == 7)
                        check(!resp_valid, "R5 no response before last word", {31'd0, resp_valid}, 32'd0);
                    fill_valid = 1'b1;
                    fill_data  = word_of({ea[31:5], 3'(k), 2'b00});
                    @(negedge clk);
                end
                fill_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int s = 0; s < 128; s++) begin
            m_plru[s] = 3'b000;
            for (int w = 0; w < 4; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check(req_ready === 1'b1, "R2 ready after reset", {31'd0, req_ready}, 32'd1);
        check(resp_valid === 1'b0 && miss_req === 1'b0, "R2 quiet after reset",
              {30'd0, resp_valid, miss_req}, 32'd0);

        // R2/R1/R4/R5 cold miss, then hits at two positions (R3)
        do_read(20'h10001, 7'd5, 3'd3, 0, 1'b0);
        do_read(20'h10001, 7'd5, 3'd3, 0, 1'b0);
        do_read(20'h10001, 7'd5, 3'd6, 0, 1'b0);

        // fill set 5 with aliases, gaps and grant delay (R4, R5, R7)
        gap_mode = 1; gnt_dly = 2;
        do_read(20'h20002, 7'd5, 3'd0, 0, 1'b0);
        gap_mode = 0; gnt_dly = 0;
        do_read(20'h30003, 7'd5, 3'd7, 2, 1'b0);
        do_read(20'h40004, 7'd5, 3'd1, 0, 1'b0);

        // R8 replacement order in a full set
        do_read(20'h20002, 7'd5, 3'd2, 0, 1'b0);
        do_read(20'h50005, 7'd5, 3'd4, 0, 1'b0);
        do_read(20'h30003, 7'd5, 3'd5, 0, 1'b0);
        do_read(20'h10001, 7'd5, 3'd0, 0, 1'b0);
        do_read(20'h20002, 7'd5, 3'd3, 0, 1'b0);
        do_read(20'h40004, 7'd5, 3'd6, 0, 1'b0);
        do_read(20'h50005, 7'd5, 3'd7, 0, 1'b0);

        // R7 invalid way before valid victim in set 9
        do_read(20'h0AAA1, 7'd9, 3'd1, 0, 1'b0);
        do_read(20'h0AAA2, 7'd9, 3'd2, 0, 1'b0);
        do_read(20'h0AAA3, 7'd9, 3'd3, 0, 1'b0);
        do_read(20'h0AAA4, 7'd9, 3'd4, 0, 1'b0);
        do_read(20'h0AAA1, 7'd9, 3'd5, 0, 1'b0);
        do_read(20'h0AAA2, 7'd9, 3'd6, 0, 1'b0);
        do_read(20'h0AAA3, 7'd9, 3'd7, 0, 1'b0);
        do_read(20'h0AAA4, 7'd9, 3'd0, 0, 1'b0);

        // R6 delayed translation on a hit; set independence (R1)
        do_read(20'h10001, 7'd5, 3'd1, 3, 1'b0);
        do_read(20'h10001, 7'd20, 3'd2, 0, 1'b0);
        do_read(20'h10001, 7'd20, 3'd2, 0, 1'b0);

        // R9 strobe while busy is ignored
        gap_mode = 1;
        do_read(20'h7F00F, 7'd127, 3'd5, 0, 1'b1);
        gap_mode = 0;
        do_read(20'h7F00F, 7'd127, 3'd0, 0, 1'b0);

        repeat (20) @(negedge clk);
        check(rq.size() == 0, "R9 no missing or extra responses", rq.size(), 32'd0);
        check(mq.size() == 0 && !miss_req, "R4 no stray line requests", mq.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule